// File: doc/BRIEF.md
# Identifier Acceptance Filter

This block sits between the serial receive logic of a bus controller and its receive FIFO. As a received standard-format message arrives, the block collects identifier bits 10 down to 3 in serial order. It then compares those eight bits with a programmable 8-bit match pattern. A second 8-bit register marks each bit position as either relevant or don't-care. When the comparison passes, the block raises an accept flag. That flag gates every byte the receiver tries to write into the FIFO, and it stays set until the end of the frame.

Both filter registers sit on a small CPU register port. They can be written and read only while the controller is held in its configuration (reset) state. At all other times, writes are dropped and reads return zero.

Top module: `can_id_filter`

## Requirements
- R1: After reset, the match register holds 00H, the don't-care register holds FFH, and `accept` is 0.
- R2: While `cfg_mode` is 1, a write to address 4 loads the match register and a write to address 5 loads the don't-care register. A read of either address returns its current value combinationally.
- R3: While `cfg_mode` is 0, CPU writes to either register leave both registers unchanged.
- R4: `cpu_rdata` is 00H whenever `cfg_mode` is 0, and also for any address other than 4 and 5.
- R5: Identifier bits arrive MSB first on `rx_bit`, qualified by `rx_bit_vld`, with identifier bit 10 first. On the clock edge that takes the eighth bit, the block registers the decision. `accept` becomes 1 from the next cycle if, in every position, (id XNOR match) OR dontcare is 1.
- R6: A don't-care bit of 1 removes that position from the comparison. A bit of 0 requires the identifier bit to equal the match bit.
- R7: Once decided, `accept` holds through any further `rx_bit_vld` pulses. It clears on `rx_sof` or `rx_eof`, and each of these also restarts bit collection. A bit presented in the same cycle as `rx_sof` or `rx_eof` is not collected.
- R8: `fifo_wr` equals `rx_store` AND `accept` AND `fifo_room` in the same cycle.
- R9: A register write in the same cycle as the eighth identifier bit takes effect only after the decision, so that decision uses the old register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Controller is in configuration (reset) state |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | ADDR_W | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| rx_sof | input | 1 | Start of a received frame |
| rx_eof | input | 1 | End of the received frame |
| rx_bit_vld | input | 1 | `rx_bit` carries an identifier bit |
| rx_bit | input | 1 | Serial identifier bit, MSB first |
| rx_store | input | 1 | Receiver wants to write a byte to the FIFO |
| fifo_room | input | 1 | FIFO has space for a byte |
| accept | output | 1 | Current frame passed the filter |
| fifo_wr | output | 1 | Gated FIFO write strobe |

## Verification
The case that needs care is a CPU write to the match register landing on the same edge as the eighth identifier bit. The bench provokes it by holding the block in configuration state while it shifts in an identifier. It issues the write together with the final bit, choosing a new value that would flip the verdict. A behavioural reference model, updated frame logic first and register writes second, predicts the verdict from the old value. The model is compared with `accept`, `fifo_wr` and `cpu_rdata` on every cycle, and a following frame then confirms that the new value took effect.

// File: rtl/can_id_filter.sv
module can_id_filter #(
  parameter int ADDR_W    = 5,
  parameter int MATCH_ADR = 4,
  parameter int DCARE_ADR = 5,
  parameter int ID_BITS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_bit_vld,
  input  logic              rx_bit,
  input  logic              rx_store,
  input  logic              fifo_room,
  output logic              accept,
  output logic              fifo_wr
);
  localparam int CW = $clog2(ID_BITS + 1);

  logic [ID_BITS-1:0] match_q, dcare_q, shreg;
  logic [CW-1:0]      cnt;
  logic               acc_q;

  wire hit_match = cpu_addr == ADDR_W'(MATCH_ADR);
  wire hit_dcare = cpu_addr == ADDR_W'(DCARE_ADR);
  wire take_bit  = rx_bit_vld && !rx_sof && !rx_eof && (cnt < CW'(ID_BITS));
  wire last_bit  = take_bit && (cnt == CW'(ID_BITS - 1));
  wire [ID_BITS-1:0] full_id = {shreg[ID_BITS-2:0], rx_bit};
  wire verdict   = &(~(full_id ^ match_q) | dcare_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      dcare_q <= '1;
    end else if (cfg_mode && cpu_wr) begin
      if (hit_match) match_q <= cpu_wdata;
      if (hit_dcare) dcare_q <= cpu_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      acc_q <= 1'b0;
    end else if (rx_sof || rx_eof) begin
      cnt   <= '0;
      acc_q <= 1'b0;
    end else if (take_bit) begin
      shreg <= full_id;
      cnt   <= cnt + 1'b1;
      if (last_bit) acc_q <= verdict;
    end
  end

  assign cpu_rdata = !cfg_mode ? 8'h00 :
                     hit_match ? match_q :
                     hit_dcare ? dcare_q : 8'h00;
  assign accept  = acc_q;
  assign fifo_wr = rx_store && acc_q && fifo_room;
endmodule

// File: rtl/can_id_filter_chk.sv
module can_id_filter_chk #(
  parameter int ADDR_W    = 5,
  parameter int MATCH_ADR = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_mode,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic [7:0]        cpu_rdata,
  input logic              rx_sof,
  input logic              rx_eof,
  input logic              rx_store,
  input logic              fifo_room,
  input logic              accept,
  input logic              fifo_wr,
  input logic [7:0]        match_q,
  input logic [7:0]        dcare_q
);
  a_r2_match_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode && cpu_wr && cpu_addr == ADDR_W'(MATCH_ADR) |=> match_q == $past(cpu_wdata));
  a_r3_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(match_q) && $stable(dcare_q));
  a_r4_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> cpu_rdata == 8'h00);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sof || rx_eof |=> !accept);
  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> accept && fifo_room && rx_store);
endmodule

bind can_id_filter can_id_filter_chk #(.ADDR_W(ADDR_W), .MATCH_ADR(MATCH_ADR)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cpu_wr(cpu_wr),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
  .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_store(rx_store), .fifo_room(fifo_room),
  .accept(accept), .fifo_wr(fifo_wr), .match_q(match_q), .dcare_q(dcare_q)
);

// File: tb/sim_can_id_filter.sv
`timescale 1ns/1ps
module sim_can_id_filter;
  logic clk = 0, rst_n = 0, cfg_mode = 1, cpu_wr = 0;
  logic [4:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic rx_sof = 0, rx_eof = 0, rx_bit_vld = 0, rx_bit = 0, rx_store = 0, fifo_room = 0;
  logic accept, fifo_wr;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  can_id_filter u0 (.*);

  // reference model
  int m_code = 0, m_mask = 255, m_cnt = 0, m_id = 0;
  bit m_acc = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_mask = 255; m_cnt = 0; m_id = 0; m_acc = 0;
    end else begin
      if (rx_sof || rx_eof) begin
        m_cnt = 0; m_acc = 0;
      end else if (rx_bit_vld && m_cnt < 8) begin
        m_id = ((m_id << 1) | int'(rx_bit)) & 255;
        m_cnt++;
        if (m_cnt == 8) m_acc = ((((~(m_id ^ m_code)) | m_mask) & 255) == 255);
      end
      if (cfg_mode && cpu_wr) begin
        if (cpu_addr == 4) m_code = cpu_wdata;
        if (cpu_addr == 5) m_mask = cpu_wdata;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    int er;
    er = !cfg_mode ? 0 : (cpu_addr == 4) ? m_code : (cpu_addr == 5) ? m_mask : 0;
    chk("R5", int'(accept), int'(m_acc));
    chk("R8", int'(fifo_wr), int'(rx_store && m_acc && fifo_room));
    chk(cfg_mode ? "R2" : "R4", int'(cpu_rdata), er);
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input int a, input int d);
    cpu_addr = a[4:0]; cpu_wdata = d[7:0]; cpu_wr = 1; tick(); cpu_wr = 0;
  endtask

  task automatic rd_at_negedge(input int a, input int exp, input string req);
    cpu_addr = a[4:0]; @(negedge clk); #0.5; chk(req, int'(cpu_rdata), exp); tick();
  endtask

  task automatic send_id(input int id, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      rx_bit_vld = 1; rx_bit = id[i]; tick();
    end
    rx_bit_vld = 0;
  endtask

  task automatic frame_start(); rx_sof = 1; tick(); rx_sof = 0; endtask
  task automatic frame_end();   rx_eof = 1; tick(); rx_eof = 0; endtask

  initial begin
    #100000;
    bad++; $display("FAIL watchdog expired");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset values
    rd_at_negedge(4, 8'h00, "R1");
    rd_at_negedge(5, 8'hFF, "R1");
    chk("R1", int'(accept), 0);
    // R2 configuration
    wr(4, 8'hA5); wr(5, 8'h00);
    rd_at_negedge(4, 8'hA5, "R2");
    rd_at_negedge(5, 8'h00, "R2");
    rd_at_negedge(7, 8'h00, "R4");
    // R3/R4 locked outside configuration
    cfg_mode = 0;
    wr(4, 8'h11); wr(5, 8'hFF);
    rd_at_negedge(4, 8'h00, "R4");
    // R5 matching identifier
    frame_start(); send_id(8'hA5, 8);
    chk("R5", int'(accept), 1);
    // R8 gating
    rx_store = 1; fifo_room = 1; @(negedge clk); #0.5; chk("R8", int'(fifo_wr), 1); tick();
    fifo_room = 0; @(negedge clk); #0.5; chk("R8", int'(fifo_wr), 0); tick();
    rx_store = 0;
    // R7 hold then clear
    send_id(8'h00, 8);
    chk("R7", int'(accept), 1);
    frame_end();
    chk("R7", int'(accept), 0);
    // R6 relevant bit mismatch
    frame_start(); send_id(8'hA4, 8);
    chk("R6", int'(accept), 0);
    frame_end();
    // R3 registers untouched by locked writes
    cfg_mode = 1;
    rd_at_negedge(4, 8'hA5, "R3");
    rd_at_negedge(5, 8'h00, "R3");
    wr(5, 8'h01);
    frame_start(); send_id(8'hA4, 8);
    chk("R6", int'(accept), 1);
    // R7 sof clears and restarts
    frame_start();
    chk("R7", int'(accept), 0);
    // R9 write coincident with last bit
    send_id(8'h5A, 7);
    rx_bit_vld = 1; rx_bit = 1'b0;
    cpu_addr = 4; cpu_wdata = 8'h5A; cpu_wr = 1; tick();
    cpu_wr = 0; rx_bit_vld = 0;
    chk("R9", int'(accept), 0);
    frame_end();
    frame_start(); send_id(8'h5A, 8);
    chk("R9", int'(accept), 1);
    frame_end();
    repeat (2) tick();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule